// File: doc/BRIEF.md
# Microphone Power-State Sequencer

This block decides when a digital microphone may put real samples on its serial output. It runs on a free-running local clock. It watches two inputs: the enable pin and the incoming bit clock (SCK). From these it keeps one of four modes: power-down, standby, waking and normal. The transmitter gets a single valid flag. Whenever that flag is low, the transmitter sends zeros.

SCK activity is judged inside the local clock domain. SCK passes through a synchroniser, and its rising edges are detected there. When no edge has arrived for a set number of local cycles, SCK counts as stopped.

Each way into the waking mode has its own count of SCK rising edges that must pass before output is released:
- reset (initial power-up);
- return from standby;
- return from power-down.

All three counts are parameters. Standby can only follow normal operation. Power-down follows the enable pin whatever SCK is doing.

Top module: `mic_pwr_seq`

## Requirements
- R1: The mode output is encoded 2'b00 power-down, 2'b01 standby, 2'b10 waking, 2'b11 normal. After reset, with the enable pin high, the mode is waking (2'b10) and `tx_valid_o` is 0.
- R2: After reset, the mode becomes normal only once `BOOT_EDGES` SCK rising edges have been seen. After `BOOT_EDGES`-1 edges it is still waking.
- R3: In normal mode with the enable pin high, when no SCK rising edge arrives for `IDLE_LIM` local clock cycles, the mode becomes standby (2'b01).
- R4: An SCK pause clearly shorter than `IDLE_LIM` local cycles leaves the mode at normal.
- R5: When the enable pin is low, the mode becomes power-down (2'b00) within a few local cycles. This holds whether SCK is running or stopped.
- R6: When the enable pin returns high in power-down, the mode becomes waking. It becomes normal after `PD_EDGES` further SCK rising edges, and not after `PD_EDGES`-1.
- R7: Standby is entered only from normal. SCK stopping while in waking mode leaves the mode at waking.
- R8: In standby, the first SCK rising edge moves the mode to waking. It becomes normal after `STBY_EDGES` further rising edges, and not before.
- R9: If the enable pin falls during a standby wake-up, the mode goes to power-down. The next wake-up uses the full `PD_EDGES` count, started afresh.
- R10: `tx_valid_o` is 1 exactly when the mode is normal. Output is muted during every wake-up count and in standby and power-down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running local clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| sck_i | input | 1 | Serial bit clock, asynchronous to `clk` |
| en_i | input | 1 | Enable pin, asynchronous, high = enabled |
| mode_o | output | 2 | Current mode (encoding in R1) |
| tx_valid_o | output | 1 | High when the transmitter may send real data |

## Verification
The bench builds the block with `BOOT_EDGES`=40, `STBY_EDGES`=10, `PD_EDGES`=20, `IDLE_LIM`=16 and a two-stage synchroniser. With these values, every wake-up path can be walked edge by edge in a few hundred cycles. The power-down count and the standby count differ, so the bench can tell which count a wake-up used. That difference is what shows the count restarting with the power-down length when the enable pin drops during a standby wake-up. SCK is driven with eight local cycles per period, well inside the idle limit, so a running clock and a stopped clock are clearly apart.

// File: rtl/mic_pwr_pkg.sv
package mic_pwr_pkg;

   // Mode encoding is visible at the top ports.
   typedef enum logic [1:0] {
      ST_PD     = 2'b00,
      ST_STBY   = 2'b01,
      ST_WAKE   = 2'b10,
      ST_NORMAL = 2'b11
   } pwr_state_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/mic_sync.sv
module mic_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("mic_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] ff_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q[i] <= RST_VAL;
            else        ff_q[i] <= d_i;
         end
      end else begin : g_rest
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q[i] <= RST_VAL;
            else        ff_q[i] <= ff_q[i-1];
         end
      end
   end

   assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/mic_sck_mon.sv
module mic_sck_mon #(
   parameter int IDLE_LIM    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_i,
   output logic rise_o,
   output logic active_o
);

   localparam int IW = $clog2(IDLE_LIM + 1);
   localparam logic [IW-1:0] LIM = IW'(IDLE_LIM);

   if (IDLE_LIM < 4) begin : g_bad_idle
      $error("mic_sck_mon: IDLE_LIM must be at least 4");
   end

   logic          sck_s;
   logic          sck_prev_q;
   logic [IW-1:0] idle_q;

   mic_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (sck_i),
      .q_o   (sck_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev_q <= 1'b0;
      else        sck_prev_q <= sck_s;
   end

   assign rise_o = sck_s & ~sck_prev_q;

   // Idle counter saturates at the limit; reset leaves SCK counted as stopped.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            idle_q <= LIM;
      else if (rise_o)       idle_q <= '0;
      else if (idle_q < LIM) idle_q <= idle_q + 1'b1;
   end

   assign active_o = (idle_q != LIM);

   a_r3_rise_wakes_active: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> active_o);

   a_r3_idle_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_o && !rise_o) |=> !active_o);

endmodule

// File: rtl/mic_wake_ctr.sv
module mic_wake_ctr #(
   parameter int CW      = 18,
   parameter int RST_LEN = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_i,
   input  logic [CW-1:0] len_i,
   input  logic          tick_i,
   output logic          done_o
);

   if (RST_LEN < 1) begin : g_bad_len
      $error("mic_wake_ctr: RST_LEN must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   // Load wins over a tick in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= CW'(RST_LEN);
      else if (ld_i)                  cnt_q <= len_i;
      else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = (cnt_q == '0);

   a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_i && cnt_q == '0) |=> cnt_q == '0);

   a_r2_one_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_i && tick_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

   a_r6_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
      ld_i |=> cnt_q == $past(len_i));

endmodule

// File: rtl/mic_pwr_seq.sv
module mic_pwr_seq
   import mic_pwr_pkg::*;
#(
   parameter int BOOT_EDGES  = 2**18,
   parameter int STBY_EDGES  = 2**14,
   parameter int PD_EDGES    = 2**17,
   parameter int IDLE_LIM    = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sck_i,
   input  logic       en_i,
   output logic [1:0] mode_o,
   output logic       tx_valid_o
);

   localparam int MAX_EDGES = max3(BOOT_EDGES, STBY_EDGES, PD_EDGES);
   localparam int CW        = $clog2(MAX_EDGES + 1);

   if (BOOT_EDGES < 1 || STBY_EDGES < 1 || PD_EDGES < 1) begin : g_bad_edges
      $error("mic_pwr_seq: wake-up edge counts must be at least 1");
   end

   logic          en_s;
   logic          sck_rise;
   logic          sck_active;
   logic          wake_done;
   logic          wake_ld;
   logic [CW-1:0] wake_len;
   pwr_state_e    state_q, state_d;
   logic          valid_q;

   // Enable assumed high across reset, so boot is not taken as power-down.
   mic_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_en_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (en_i),
      .q_o   (en_s)
   );

   mic_sck_mon #(.IDLE_LIM(IDLE_LIM), .SYNC_STAGES(SYNC_STAGES)) u_sck_mon (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck_i    (sck_i),
      .rise_o   (sck_rise),
      .active_o (sck_active)
   );

   mic_wake_ctr #(.CW(CW), .RST_LEN(BOOT_EDGES)) u_wake (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld_i   (wake_ld),
      .len_i  (wake_len),
      .tick_i (sck_rise),
      .done_o (wake_done)
   );

   always_comb begin
      state_d  = state_q;
      wake_ld  = 1'b0;
      wake_len = '0;
      unique case (state_q)
         ST_WAKE: begin
            if (!en_s)          state_d = ST_PD;
            else if (wake_done) state_d = ST_NORMAL;
         end
         ST_NORMAL: begin
            if (!en_s)            state_d = ST_PD;
            else if (!sck_active) state_d = ST_STBY;
         end
         ST_STBY: begin
            if (!en_s) begin
               state_d = ST_PD;
            end else if (sck_active) begin
               state_d  = ST_WAKE;
               wake_ld  = 1'b1;
               wake_len = CW'(STBY_EDGES);
            end
         end
         ST_PD: begin
            if (en_s) begin
               state_d  = ST_WAKE;
               wake_ld  = 1'b1;
               wake_len = CW'(PD_EDGES);
            end
         end
         default: state_d = ST_PD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_WAKE;
         valid_q <= 1'b0;
      end else begin
         state_q <= state_d;
         valid_q <= (state_d == ST_NORMAL);
      end
   end

   assign mode_o     = state_q;
   assign tx_valid_o = valid_q;

   a_r10_valid_iff_normal: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid_o == (state_q == ST_NORMAL));

   a_r5_enable_low_powers_down: assert property (@(posedge clk) disable iff (!rst_n)
      !en_s |=> state_q == ST_PD);

   a_r7_standby_from_normal: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_STBY && $past(state_q) != ST_STBY) |-> $past(state_q) == ST_NORMAL);

   a_r6_normal_after_count: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_NORMAL && $past(state_q) == ST_WAKE) |-> $past(wake_done));

   a_r9_no_pd_to_standby: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PD) |=> state_q != ST_STBY);

endmodule

// File: tb/sim_mic_pwr_seq.sv
module sim_mic_pwr_seq;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       sck;
   logic       en;
   logic [1:0] mode;
   logic       valid;

   int n_vec  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [2:0] exp_q[$];
   string      tag_q[$];

   always #5 clk = ~clk;

   mic_pwr_seq #(
      .BOOT_EDGES (40),
      .STBY_EDGES (10),
      .PD_EDGES   (20),
      .IDLE_LIM   (16),
      .SYNC_STAGES(2)
   ) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .sck_i      (sck),
      .en_i       (en),
      .mode_o     (mode),
      .tx_valid_o (valid)
   );

   // Monitor: pops expectations and compares on the falling edge.
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [2:0] e;
         string      t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_vec++;
         if ({mode, valid} !== e) begin
            n_fail++;
            $display("FAIL %s: actual mode=%b valid=%b expected mode=%b valid=%b",
                     t, mode, valid, e[2:1], e[0]);
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         sck = 1'b1; step(4);
         sck = 1'b0; step(4);
      end
   endtask

   task automatic expect_out(input logic [1:0] m, input logic v, input string t);
      exp_q.push_back({m, v});
      tag_q.push_back(t);
      @(negedge clk);
      #1;
   endtask

   initial begin
      rst_n = 1'b0; sck = 1'b0; en = 1'b1;
      step(5);
      rst_n = 1'b1;
      step(1);
      expect_out(2'b10, 1'b0, "R1 reset state waking, muted");

      pulses(39);
      expect_out(2'b10, 1'b0, "R2 boot count one edge short");
      pulses(1);
      expect_out(2'b11, 1'b1, "R2 boot count complete, R10 valid");

      step(4);
      expect_out(2'b11, 1'b1, "R4 short SCK pause keeps normal");
      step(30);
      expect_out(2'b01, 1'b0, "R3 SCK stop enters standby");

      pulses(1);
      expect_out(2'b10, 1'b0, "R8 restart edge leaves standby");
      pulses(9);
      expect_out(2'b10, 1'b0, "R8 standby count one edge short");
      pulses(1);
      expect_out(2'b11, 1'b1, "R8 standby count complete");

      en = 1'b0;
      pulses(2);
      expect_out(2'b00, 1'b0, "R5 enable low with SCK running");
      step(30);
      expect_out(2'b00, 1'b0, "R5 enable low with SCK stopped");

      en = 1'b1;
      step(6);
      expect_out(2'b10, 1'b0, "R6 enable high starts wake-up");
      step(30);
      expect_out(2'b10, 1'b0, "R7 SCK stop while waking stays waking");
      pulses(19);
      expect_out(2'b10, 1'b0, "R6 power-down count one edge short");
      pulses(1);
      expect_out(2'b11, 1'b1, "R6 power-down count complete");

      step(30);
      expect_out(2'b01, 1'b0, "R3 standby again");
      pulses(6);
      expect_out(2'b10, 1'b0, "R9 standby wake-up in progress");
      en = 1'b0;
      step(6);
      expect_out(2'b00, 1'b0, "R9 enable drop during wake-up powers down");
      en = 1'b1;
      step(6);
      expect_out(2'b10, 1'b0, "R9 wake-up from power-down");
      pulses(19);
      expect_out(2'b10, 1'b0, "R9 uses full power-down count");
      pulses(1);
      expect_out(2'b11, 1'b1, "R9 power-down count complete, R10 valid");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog (all requirements): actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

endmodule